// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the outcome of a control-transfer instruction for an 8-bit-datapath processor core. Each request carries a transfer kind, a condition code, the current packed flags byte, the current program counter, an immediate operand and a return address that the stack side has already popped. One clock later the unit presents a registered result: whether the transfer is taken, the next program counter, whether a return address must be pushed or a stack entry consumed, and how many clock cycles the instruction costs.

Stack memory, instruction fetch and decode stay outside. The surrounding pipeline uses the push and pop strobes to drive its own stack logic and the cycle cost to pace its timing model. Requests may arrive on every clock, and each one yields exactly one result.

The control is a two-state machine. ST_IDLE means no result is on the outputs. ST_RESULT means the outputs hold the result of the request sampled at the last edge. The machine moves from either state to ST_RESULT when a request is present at the edge (transition "accept"), and to ST_IDLE when no request is present (transition "drain"). Reset forces ST_IDLE.

Top module: `branch_resolver`

## Requirements
- R1: While reset is low, and after reset until the first request, `res_valid`, `res_push` and `res_pop` are 0.
- R2: A request sampled with `req_valid` high at a rising edge gives `res_valid` high for the cycle after that edge. A cycle without a request gives `res_valid` low in the next cycle. Back-to-back requests give back-to-back results.
- R3: Condition codes on `req_cond`: 0 always, 1 taken when the zero flag is clear, 2 taken when it is set, 3 taken when the carry flag is clear, 4 taken when it is set. The zero flag is bit 7 of `req_flags` and the carry flag is bit 4. The other flag bits have no effect.
- R4: Condition codes 5, 6 and 7 behave exactly like code 0, so the transfer is always taken.
- R5: Kind 0 (relative): the taken target is `req_pc` plus the sign-extended `req_imm[7:0]`, wrapping modulo 65536. `req_imm[15:8]` is ignored. The cost is 12 when taken and 8 when not taken.
- R6: Kind 1 (absolute): the taken target is `req_imm`. The cost is 16 when taken and 12 when not taken.
- R7: Kind 2 (call): the taken target is `req_imm` and `res_push` is 1. The cost is 24 when taken and 12 when not taken. `res_push` is never 1 for any other kind.
- R8: Kind 3 (return): the taken target is `req_ret_addr` and `res_pop` is 1. The cost is 20 when taken through codes 1 to 4, 8 when not taken, and 16 when unconditional (codes 0, 5, 6, 7). `res_pop` is never 1 for any other kind.
- R9: When not taken, `res_next_pc` equals the request's `req_pc`, and both `res_push` and `res_pop` are 0.
- R10: In any cycle where `res_valid` is 0, `res_push` and `res_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | Transfer kind: 0 relative, 1 absolute, 2 call, 3 return |
| req_cond | input | 3 | Condition code (see R3, R4) |
| req_flags | input | 8 | Packed flags byte: zero at bit 7, carry at bit 4 |
| req_pc | input | 16 | Current program counter |
| req_imm | input | 16 | Absolute or call target; low byte is the signed relative offset |
| req_ret_addr | input | 16 | Return address already popped from the stack |
| res_valid | output | 1 | Result of the previous cycle's request is present |
| res_taken | output | 1 | The transfer is taken |
| res_next_pc | output | 16 | Program counter after the instruction |
| res_push | output | 1 | Push the current program counter (taken call) |
| res_pop | output | 1 | A stack entry is consumed (taken return) |
| res_cycles | output | 5 | Cycle cost of the instruction |

## Verification
A state register stuck in ST_RESULT or ST_IDLE shows up at the port as a `res_valid` that does not track the previous cycle's `req_valid`. The per-clock comparison catches this in the first cycle after a request or after a gap. A wrong captured field, such as a bad flag bit pick, a missing sign extension or a swapped cost, appears on the very result that follows the request. Stale push or pop strobes appear on the first idle cycle after a taken call or return. The bench therefore compares every output on every clock against a behavioural model, so any fault is reported in the same cycle it first reaches the ports.

// File: rtl/br_pkg.sv
package br_pkg;

    typedef enum logic [1:0] {
        KIND_REL  = 2'd0,
        KIND_ABS  = 2'd1,
        KIND_CALL = 2'd2,
        KIND_RET  = 2'd3
    } br_kind_e;

    localparam int unsigned COND_W = 3;

    localparam logic [COND_W-1:0] CC_ALWAYS = 3'd0;
    localparam logic [COND_W-1:0] CC_NZ     = 3'd1;
    localparam logic [COND_W-1:0] CC_Z      = 3'd2;
    localparam logic [COND_W-1:0] CC_NC     = 3'd3;
    localparam logic [COND_W-1:0] CC_C      = 3'd4;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } br_state_e;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval #(
    parameter int unsigned FLAG_W    = 8,
    parameter int unsigned ZERO_BIT  = 7,
    parameter int unsigned CARRY_BIT = 4
) (
    input  logic [br_pkg::COND_W-1:0] cond,
    input  logic [FLAG_W-1:0]         flags,
    output logic                      take,
    output logic                      uncond
);
    import br_pkg::*;

    logic zf;
    logic cf;

    assign zf = flags[ZERO_BIT];
    assign cf = flags[CARRY_BIT];

    always_comb begin
        take   = 1'b1;
        uncond = 1'b0;
        case (cond)
            CC_NZ:   take = ~zf;
            CC_Z:    take = zf;
            CC_NC:   take = ~cf;
            CC_C:    take = cf;
            default: uncond = 1'b1;
        endcase
    end

endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFS_W  = 8
) (
    input  br_pkg::br_kind_e  kind,
    input  logic              take,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] imm,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] next_pc
);
    import br_pkg::*;

    localparam int unsigned EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] rel_sum;

    assign ofs_ext = {{EXT_W{imm[OFS_W-1]}}, imm[OFS_W-1:0]};
    assign rel_sum = pc + ofs_ext;

    always_comb begin
        next_pc = pc;
        if (take) begin
            unique case (kind)
                KIND_REL:  next_pc = rel_sum;
                KIND_ABS:  next_pc = imm;
                KIND_CALL: next_pc = imm;
                KIND_RET:  next_pc = ret_addr;
            endcase
        end
    end

endmodule

// File: rtl/br_cost_table.sv
module br_cost_table #(
    parameter int unsigned CYC_W          = 5,
    parameter int unsigned REL_TAKEN      = 12,
    parameter int unsigned REL_SKIP       = 8,
    parameter int unsigned ABS_TAKEN      = 16,
    parameter int unsigned ABS_SKIP       = 12,
    parameter int unsigned CALL_TAKEN     = 24,
    parameter int unsigned CALL_SKIP      = 12,
    parameter int unsigned RET_TAKEN      = 20,
    parameter int unsigned RET_SKIP       = 8,
    parameter int unsigned RET_UNCOND     = 16
) (
    input  br_pkg::br_kind_e  kind,
    input  logic              take,
    input  logic              uncond,
    output logic [CYC_W-1:0]  cycles
);
    import br_pkg::*;

    always_comb begin
        cycles = '0;
        unique case (kind)
            KIND_REL:  cycles = take ? CYC_W'(REL_TAKEN)  : CYC_W'(REL_SKIP);
            KIND_ABS:  cycles = take ? CYC_W'(ABS_TAKEN)  : CYC_W'(ABS_SKIP);
            KIND_CALL: cycles = take ? CYC_W'(CALL_TAKEN) : CYC_W'(CALL_SKIP);
            KIND_RET: begin
                if (uncond)    cycles = CYC_W'(RET_UNCOND);
                else if (take) cycles = CYC_W'(RET_TAKEN);
                else           cycles = CYC_W'(RET_SKIP);
            end
        endcase
    end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned FLAG_W    = 8,
    parameter int unsigned ZERO_BIT  = 7,
    parameter int unsigned CARRY_BIT = 4,
    parameter int unsigned CYC_W     = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_kind,
    input  logic [br_pkg::COND_W-1:0] req_cond,
    input  logic [FLAG_W-1:0]         req_flags,
    input  logic [ADDR_W-1:0]         req_pc,
    input  logic [ADDR_W-1:0]         req_imm,
    input  logic [ADDR_W-1:0]         req_ret_addr,
    output logic                      res_valid,
    output logic                      res_taken,
    output logic [ADDR_W-1:0]         res_next_pc,
    output logic                      res_push,
    output logic                      res_pop,
    output logic [CYC_W-1:0]          res_cycles
);
    import br_pkg::*;

    br_kind_e          kind;
    logic              take;
    logic              uncond;
    logic [ADDR_W-1:0] next_pc;
    logic [CYC_W-1:0]  cycles;
    br_state_e         state_q;
    br_state_e         state_d;

    assign kind = br_kind_e'(req_kind);

    br_cond_eval #(
        .FLAG_W   (FLAG_W),
        .ZERO_BIT (ZERO_BIT),
        .CARRY_BIT(CARRY_BIT)
    ) u_cond (
        .cond  (req_cond),
        .flags (req_flags),
        .take  (take),
        .uncond(uncond)
    );

    br_target_calc #(
        .ADDR_W(ADDR_W)
    ) u_target (
        .kind    (kind),
        .take    (take),
        .pc      (req_pc),
        .imm     (req_imm),
        .ret_addr(req_ret_addr),
        .next_pc (next_pc)
    );

    br_cost_table #(
        .CYC_W(CYC_W)
    ) u_cost (
        .kind  (kind),
        .take  (take),
        .uncond(uncond),
        .cycles(cycles)
    );

    // next-state: "accept" on a request, "drain" otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_taken   <= 1'b0;
            res_next_pc <= '0;
            res_push    <= 1'b0;
            res_pop     <= 1'b0;
            res_cycles  <= '0;
        end else if (req_valid) begin
            res_taken   <= take;
            res_next_pc <= next_pc;
            res_push    <= take && (kind == KIND_CALL);
            res_pop     <= take && (kind == KIND_RET);
            res_cycles  <= cycles;
        end else begin
            res_push    <= 1'b0;
            res_pop     <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/br_checker.sv
module br_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CYC_W  = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [1:0]                req_kind,
    input logic [br_pkg::COND_W-1:0] req_cond,
    input logic [ADDR_W-1:0]         req_pc,
    input logic [ADDR_W-1:0]         req_imm,
    input logic [ADDR_W-1:0]         req_ret_addr,
    input logic                      res_valid,
    input logic                      res_taken,
    input logic [ADDR_W-1:0]         res_next_pc,
    input logic                      res_push,
    input logic                      res_pop,
    input logic [CYC_W-1:0]          res_cycles
);

    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    a_r2_no_result_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    a_r4_high_codes_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cond > 3'd4) |=> res_taken);

    a_r6_abs_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1) |=> (!res_taken || res_next_pc == $past(req_imm)));

    a_r7_push_only_call: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'd2) |=> !res_push);

    a_r8_pop_only_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'd3) |=> !res_pop);

    a_r8_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> (!res_taken || res_next_pc == $past(req_ret_addr)));

    a_r9_skip_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_taken || res_next_pc == $past(req_pc)));

    a_r9_skip_no_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> (!res_push && !res_pop));

    a_r9_skip_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> (res_cycles == 5'd8 || res_cycles == 5'd12));

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_push && !res_pop));

    a_r7_stack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_push, res_pop}));

endmodule

bind branch_resolver br_checker #(
    .ADDR_W(ADDR_W),
    .CYC_W (CYC_W)
) u_br_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_cond    (req_cond),
    .req_pc      (req_pc),
    .req_imm     (req_imm),
    .req_ret_addr(req_ret_addr),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_next_pc (res_next_pc),
    .res_push    (res_push),
    .res_pop     (res_pop),
    .res_cycles  (res_cycles)
);

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_cond = '0;
    logic [7:0]  req_flags = '0;
    logic [15:0] req_pc = '0;
    logic [15:0] req_imm = '0;
    logic [15:0] req_ret_addr = '0;
    logic        res_valid;
    logic        res_taken;
    logic [15:0] res_next_pc;
    logic        res_push;
    logic        res_pop;
    logic [4:0]  res_cycles;

    int tests = 0;
    int fails = 0;
    int cyc_count = 0;
    bit checking = 1'b0;

    // expected values, produced by the model at each rising edge
    bit exp_valid = 1'b0;
    bit exp_taken = 1'b0;
    int exp_pc    = 0;
    bit exp_push  = 1'b0;
    bit exp_pop   = 1'b0;
    int exp_cyc   = 0;
    int exp_kind  = 0;
    int exp_cond  = 0;

    always #4 clk = ~clk;  // 125 MHz

    branch_resolver u_branch_resolver (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_cond    (req_cond),
        .req_flags   (req_flags),
        .req_pc      (req_pc),
        .req_imm     (req_imm),
        .req_ret_addr(req_ret_addr),
        .res_valid   (res_valid),
        .res_taken   (res_taken),
        .res_next_pc (res_next_pc),
        .res_push    (res_push),
        .res_pop     (res_pop),
        .res_cycles  (res_cycles)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
                     tag, what, act, act, exp, exp, $time);
        end
    endtask

    // behavioural reference from the requirements
    task automatic model(input int kind, input int cond, input int flags,
                         input int pc, input int imm, input int ra,
                         output bit tk, output int npc, output int cyc,
                         output bit push, output bit pop);
        bit z;
        bit c;
        bit unc;
        int ofs;
        z = flags[7];
        c = flags[4];
        unc = 1'b0;
        case (cond)
            1: tk = !z;
            2: tk = z;
            3: tk = !c;
            4: tk = c;
            default: begin tk = 1'b1; unc = 1'b1; end
        endcase
        ofs = imm % 256;
        if (ofs >= 128) ofs = ofs - 256;
        npc = pc;
        case (kind)
            0: begin cyc = tk ? 12 : 8;  if (tk) npc = (pc + ofs + 65536) % 65536; end
            1: begin cyc = tk ? 16 : 12; if (tk) npc = imm; end
            2: begin cyc = tk ? 24 : 12; if (tk) npc = imm; end
            default: begin
                cyc = unc ? 16 : (tk ? 20 : 8);
                if (tk) npc = ra;
            end
        endcase
        push = tk && kind == 2;
        pop  = tk && kind == 3;
    endtask

    always @(posedge clk) begin
        bit tk;
        int npc;
        int cyc;
        bit ps;
        bit pp;
        cyc_count++;
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_push  <= 1'b0;
            exp_pop   <= 1'b0;
        end else begin
            exp_valid <= req_valid;
            if (req_valid) begin
                model(int'(req_kind), int'(req_cond), int'(req_flags), int'(req_pc),
                      int'(req_imm), int'(req_ret_addr), tk, npc, cyc, ps, pp);
                exp_taken <= tk;
                exp_pc    <= npc;
                exp_cyc   <= cyc;
                exp_push  <= ps;
                exp_pop   <= pp;
                exp_kind  <= int'(req_kind);
                exp_cond  <= int'(req_cond);
            end else begin
                exp_push <= 1'b0;
                exp_pop  <= 1'b0;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        string ktag;
        string ctag;
        if (checking) begin
            chk(res_valid == exp_valid, "R2", "res_valid", int'(res_valid), int'(exp_valid));
            if (!exp_valid) begin
                chk(!res_push && !res_pop, "R10", "push|pop idle",
                    int'({res_push, res_pop}), 0);
            end else begin
                case (exp_kind)
                    0: ktag = "R5";
                    1: ktag = "R6";
                    2: ktag = "R7";
                    default: ktag = "R8";
                endcase
                if (!exp_taken) ktag = "R9";
                ctag = (exp_cond > 4) ? "R4" : "R3";
                chk(res_taken == exp_taken, ctag, "res_taken", int'(res_taken), int'(exp_taken));
                chk(int'(res_next_pc) == exp_pc, ktag, "res_next_pc", int'(res_next_pc), exp_pc);
                chk(int'(res_cycles) == exp_cyc, ktag, "res_cycles", int'(res_cycles), exp_cyc);
                chk(res_push == exp_push, exp_taken ? "R7" : "R9", "res_push",
                    int'(res_push), int'(exp_push));
                chk(res_pop == exp_pop, exp_taken ? "R8" : "R9", "res_pop",
                    int'(res_pop), int'(exp_pop));
            end
        end
    end

    task automatic drive(input int kind, input int cond, input int flags,
                         input int pc, input int imm, input int ra);
        @(negedge clk);
        req_valid    = 1'b1;
        req_kind     = 2'(kind);
        req_cond     = 3'(cond);
        req_flags    = 8'(flags);
        req_pc       = 16'(pc);
        req_imm      = 16'(imm);
        req_ret_addr = 16'(ra);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        if (cyc_count > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc_count);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int flag_set[5];
        flag_set = '{8'h00, 8'h80, 8'h10, 8'h90, 8'h6F};

        // R1: outputs quiet while reset is held and just after
        repeat (3) @(negedge clk);
        chk(!res_valid && !res_push && !res_pop, "R1", "reset outputs",
            int'({res_valid, res_push, res_pop}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!res_valid && !res_push && !res_pop, "R1", "post-reset outputs",
            int'({res_valid, res_push, res_pop}), 0);
        checking = 1'b1;

        // R3, R4, R5..R9: every kind, every code, flag patterns with other bits noisy
        for (int k = 0; k < 4; k++)
            for (int c = 0; c < 8; c++)
                for (int f = 0; f < 5; f++)
                    drive(k, c, flag_set[f], 16'h1234 + 16 * c, 16'hA5F0 + f, 16'h4321);
        idle();

        // R5: wrap forward, wrap backward, upper immediate byte ignored
        drive(0, 0, 0, 16'hFFF0, 16'h0020, 0);
        drive(0, 0, 0, 16'h0005, 16'h00F0, 0);
        drive(0, 0, 0, 16'h0100, 16'hAB05, 0);
        drive(0, 0, 0, 16'h0080, 16'h0080, 0);
        idle();
        idle();

        // R7, R8 then gap: R10 strobes must drop
        drive(2, 0, 0, 16'h0200, 16'h3000, 0);
        idle();
        drive(3, 4, 8'h10, 16'h0300, 0, 16'h0BEE);
        idle();
        drive(3, 0, 0, 16'h0300, 0, 16'h0CAF);
        idle();

        // mixed traffic with gaps (R2 back-to-back and idle cycles)
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) idle();
            else drive($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 255),
                       $urandom_range(0, 65535), $urandom_range(0, 65535),
                       $urandom_range(0, 65535));
        end
        idle();
        idle();
        idle();
        checking = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule